// File: doc/BRIEF.md
# Descriptor-Chained Scatter-Gather DMA Engine

This block is the bus-master part of a storage controller. It moves a command's data between system memory and a sector-addressed storage port. The data sits in memory as a list of regions. Software places a table of 8-byte descriptors in memory and arms the engine. It then issues a go strobe that carries the table address. The engine reads one descriptor at a time and moves that region, then either fetches the next descriptor or stops. It stops when the region just finished had its last-entry flag set. At that point it reports completion to the device state machine.

Memory traffic is cut into requests that never cross a page. A descriptor fetch that meets a busy memory port is retried after a fixed wait. When data flows toward storage, a whole region is read from memory before its sectors are written out. When data flows toward memory, the region's sectors are read before the memory writes start. Per-direction traffic counters record every data request.

Top module: `sg_dma_engine`

## Requirements
- R1: The first descriptor fetch is an 8-byte memory read (mem_len_o = 8, mem_we_o = 0) at table_base_i with its two low bits cleared.
- R2: A descriptor is 64 bits. Bits [31:0] hold the region address and bits [47:32] the byte count, where 0 means 65536. Bit 63 is the last-entry flag. Each fetch after the first reads the address 8 above the previous fetch.
- R3: A region is covered by ascending memory requests. Each request's length is the smaller of the bytes left in the region and the bytes up to the next PAGE_BYTES boundary.
- R4: If mem_busy_i is high when a descriptor fetch is due, no request is made. The fetch is retried after BACKOFF_CYC idle cycles, so it appears BACKOFF_CYC+1 cycles later than it would without the busy cycle. mem_req_o is never high while mem_busy_i is high.
- R5: With to_storage_i = 1, each region is read from memory in full (mem_we_o = 0). Then one storage write (stor_we_o = 1) is issued per 512-byte sector. The sector addresses are consecutive, start at lba_i and carry on across regions.
- R6: With to_storage_i = 0, each region's sectors are read first (stor_we_o = 0, consecutive addresses from lba_i). Then the region is written to memory (mem_we_o = 1).
- R7: When the last-entry region finishes, done_o pulses for one cycle and phase_o returns to 0. done_err_o is 0 if the sectors moved times 512 equals cmd_bytes_i and 1 otherwise. A region without the flag is followed by the next fetch.
- R8: Since reset, the counters hold the bytes, the request count and the count of requests exactly PAGE_BYTES long. Memory reads and memory writes are counted separately. Descriptor fetches are not counted.
- R9: phase_o reads 0 when idle, 1 when armed and 2 during a transfer. arm_i moves the engine from idle to armed. go_i while not armed, or abort_i while idle, pulses misuse_o and has no other effect.
- R10: abort_i during a transfer allows no new memory or storage request after the cycle it is seen. The engine then ends with done_o and done_err_o = 1. abort_i while armed ends at once with an error completion.
- R11: After reset, phase_o is 0, all request and done outputs are 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Move from idle to armed |
| go_i | input | 1 | Start strobe; samples the four operands below |
| table_base_i | input | 32 | Descriptor table address (bits 1:0 ignored) |
| to_storage_i | input | 1 | 1: memory to storage, 0: storage to memory |
| lba_i | input | 32 | First sector address |
| cmd_bytes_i | input | 32 | Byte total the command expects |
| abort_i | input | 1 | Stop request |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_we_o | output | 1 | 1: memory write, 0: memory read |
| mem_addr_o | output | 32 | Request byte address |
| mem_len_o | output | 17 | Request length in bytes |
| mem_busy_i | input | 1 | Memory port cannot accept a request |
| mem_ack_i | input | 1 | Request finished |
| mem_rdata_i | input | 64 | Descriptor data, valid with mem_ack_i |
| stor_req_o | output | 1 | One-cycle sector request |
| stor_we_o | output | 1 | 1: sector write, 0: sector read |
| stor_lba_o | output | 32 | Sector address |
| stor_ack_i | input | 1 | Sector operation finished |
| phase_o | output | 2 | 0 idle, 1 armed, 2 transferring |
| done_o | output | 1 | Completion pulse |
| done_err_o | output | 1 | Error flag, valid with done_o |
| misuse_o | output | 1 | Protocol misuse pulse |
| rd_bytes_o | output | 32 | Bytes read from memory |
| rd_txn_o | output | 32 | Memory read requests |
| rd_full_o | output | 32 | Full-page memory reads |
| wr_bytes_o | output | 32 | Bytes written to memory |
| wr_txn_o | output | 32 | Memory write requests |
| wr_full_o | output | 32 | Full-page memory writes |

## Verification
The assertions take two things for granted about the ports. Each request gets exactly one ack on its own port, at least one cycle later, and no ack arrives without a request. Every descriptor byte count is a nonzero multiple of 512 or zero. The bench's responder holds one outstanding request per port and acks each after a short random delay. It only toggles busy between requests. All generated regions are 512-byte multiples, so the stimulus never leaves these limits.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;

    localparam int SECTOR_BYTES = 512;
    localparam int SECTOR_SHIFT = 9;
    localparam int DESC_BYTES   = 8;
    localparam int LEN_W        = 17;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FETCH,
        ST_BACKOFF,
        ST_FETCH_RSP,
        ST_MEM,
        ST_MEM_RSP,
        ST_SEC,
        ST_SEC_RSP,
        ST_REGION_END
    } eng_state_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_XFER  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [31:0]      base;
        logic [LEN_W-1:0] bytes;
        logic             last;
    } region_t;

    // Unpack one descriptor; a zero count stands for 64 KiB.
    function automatic region_t decode_desc(input logic [63:0] raw);
        region_t r;
        r.base  = raw[31:0];
        r.bytes = (raw[47:32] == 16'd0) ? LEN_W'(65536) : {1'b0, raw[47:32]};
        r.last  = raw[63];
        return r;
    endfunction

endpackage

// File: rtl/sg_chunker.sv
module sg_chunker #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 17,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  left_i,
    output logic [LEN_W-1:0]  len_o
);
    localparam int PG_W = $clog2(PAGE_BYTES);

    logic [LEN_W-1:0] to_page;

    always_comb begin
        to_page = LEN_W'(PAGE_BYTES) - LEN_W'(addr_i[PG_W-1:0]);
        len_o   = (left_i < to_page) ? left_i : to_page;
    end
endmodule

// File: rtl/sg_stats.sv
module sg_stats #(
    parameter int LEN_W      = 17,
    parameter int STAT_W     = 32,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_i,
    input  logic              is_read_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [STAT_W-1:0] bytes_o [2],
    output logic [STAT_W-1:0] txn_o   [2],
    output logic [STAT_W-1:0] full_o  [2]
);
    // index 0 counts memory reads, index 1 memory writes
    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic              sel;
        logic [STAT_W-1:0] n_bytes, n_txn, n_full;

        assign sel = hit_i && (is_read_i == (d == 0));

        always_ff @(posedge clk) begin
            if (rst) begin
                n_bytes <= '0;
                n_txn   <= '0;
                n_full  <= '0;
            end else if (sel) begin
                n_bytes <= n_bytes + STAT_W'(len_i);
                n_txn   <= n_txn + 1'b1;
                if (len_i == LEN_W'(PAGE_BYTES))
                    n_full <= n_full + 1'b1;
            end
        end

        assign bytes_o[d] = n_bytes;
        assign txn_o[d]   = n_txn;
        assign full_o[d]  = n_full;

        // R8: full-page requests are a subset of all requests
        a_r8_full_le_txn: assert property (@(posedge clk) disable iff (rst)
            n_full <= n_txn);
    end
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
    import sg_dma_pkg::*;
#(
    parameter int PAGE_BYTES  = 4096,
    parameter int BACKOFF_CYC = 8,
    parameter int STAT_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              go_i,
    input  logic [31:0]       table_base_i,
    input  logic              to_storage_i,
    input  logic [31:0]       lba_i,
    input  logic [31:0]       cmd_bytes_i,
    input  logic              abort_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [16:0]       mem_len_o,
    input  logic              mem_busy_i,
    input  logic              mem_ack_i,
    input  logic [63:0]       mem_rdata_i,
    output logic              stor_req_o,
    output logic              stor_we_o,
    output logic [31:0]       stor_lba_o,
    input  logic              stor_ack_i,
    output logic [1:0]        phase_o,
    output logic              done_o,
    output logic              done_err_o,
    output logic              misuse_o,
    output logic [STAT_W-1:0] rd_bytes_o,
    output logic [STAT_W-1:0] rd_txn_o,
    output logic [STAT_W-1:0] rd_full_o,
    output logic [STAT_W-1:0] wr_bytes_o,
    output logic [STAT_W-1:0] wr_txn_o,
    output logic [STAT_W-1:0] wr_full_o
);
    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam int BO_W = $clog2(BACKOFF_CYC + 1);

    eng_state_e       st;
    logic [31:0]      ptr;
    logic [31:0]      rem_cmd;
    logic [31:0]      lba;
    logic             m2s;
    logic             last_q;
    logic [31:0]      cur_addr;
    logic [LEN_W-1:0] mem_left;
    logic [LEN_W-1:0] sec_left;
    logic [BO_W-1:0]  bo_cnt;
    logic             abort_pend;
    logic [LEN_W-1:0] chunk_len;
    region_t          fetched;

    logic unused_rsvd;
    assign unused_rsvd = ^{mem_rdata_i[62:48], table_base_i[1:0]};

    sg_chunker #(.ADDR_W(32), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
        .addr_i (cur_addr),
        .left_i (mem_left),
        .len_o  (chunk_len)
    );

    logic [STAT_W-1:0] s_bytes [2];
    logic [STAT_W-1:0] s_txn   [2];
    logic [STAT_W-1:0] s_full  [2];

    sg_stats #(.LEN_W(LEN_W), .STAT_W(STAT_W), .PAGE_BYTES(PAGE_BYTES)) u_stats (
        .clk       (clk),
        .rst       (rst),
        .hit_i     (st == ST_MEM_RSP && mem_ack_i),
        .is_read_i (m2s),
        .len_i     (chunk_len),
        .bytes_o   (s_bytes),
        .txn_o     (s_txn),
        .full_o    (s_full)
    );

    assign rd_bytes_o = s_bytes[0];
    assign rd_txn_o   = s_txn[0];
    assign rd_full_o  = s_full[0];
    assign wr_bytes_o = s_bytes[1];
    assign wr_txn_o   = s_txn[1];
    assign wr_full_o  = s_full[1];

    always_comb begin
        fetched    = decode_desc(mem_rdata_i);
        mem_req_o  = (st == ST_FETCH || st == ST_MEM) && !mem_busy_i && !abort_pend;
        mem_we_o   = (st == ST_MEM) && !m2s;
        mem_addr_o = (st == ST_FETCH) ? ptr : cur_addr;
        mem_len_o  = (st == ST_FETCH) ? LEN_W'(DESC_BYTES) : chunk_len;
        stor_req_o = (st == ST_SEC) && !abort_pend;
        stor_we_o  = m2s;
        stor_lba_o = lba;
        case (st)
            ST_IDLE:  phase_o = PH_IDLE;
            ST_ARMED: phase_o = PH_ARMED;
            default:  phase_o = PH_XFER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ptr        <= '0;
            rem_cmd    <= '0;
            lba        <= '0;
            m2s        <= 1'b0;
            last_q     <= 1'b0;
            cur_addr   <= '0;
            mem_left   <= '0;
            sec_left   <= '0;
            bo_cnt     <= '0;
            abort_pend <= 1'b0;
            done_o     <= 1'b0;
            done_err_o <= 1'b0;
            misuse_o   <= 1'b0;
        end else begin
            done_o     <= 1'b0;
            done_err_o <= 1'b0;
            misuse_o   <= 1'b0;
            if (abort_i && st != ST_IDLE && st != ST_ARMED)
                abort_pend <= 1'b1;
            if (go_i && st != ST_ARMED)
                misuse_o <= 1'b1;

            case (st)
                ST_IDLE: begin
                    if (abort_i)
                        misuse_o <= 1'b1;
                    else if (arm_i && !go_i)
                        st <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (abort_i) begin
                        st         <= ST_IDLE;
                        done_o     <= 1'b1;
                        done_err_o <= 1'b1;
                    end else if (go_i) begin
                        ptr     <= {table_base_i[31:2], 2'b00};
                        rem_cmd <= cmd_bytes_i;
                        lba     <= lba_i;
                        m2s     <= to_storage_i;
                        st      <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (abort_pend) begin
                        st         <= ST_IDLE;
                        done_o     <= 1'b1;
                        done_err_o <= 1'b1;
                        abort_pend <= 1'b0;
                    end else if (mem_busy_i) begin
                        bo_cnt <= BO_W'(BACKOFF_CYC - 1);
                        st     <= ST_BACKOFF;
                    end else begin
                        st <= ST_FETCH_RSP;
                    end
                end
                ST_BACKOFF: begin
                    if (bo_cnt == '0) st <= ST_FETCH;
                    else              bo_cnt <= bo_cnt - 1'b1;
                end
                ST_FETCH_RSP: begin
                    if (mem_ack_i) begin
                        cur_addr <= fetched.base;
                        mem_left <= fetched.bytes;
                        sec_left <= fetched.bytes >> SECTOR_SHIFT;
                        last_q   <= fetched.last;
                        ptr      <= ptr + 32'(DESC_BYTES);
                        st       <= m2s ? ST_MEM : ST_SEC;
                    end
                end
                ST_MEM: begin
                    if (abort_pend) begin
                        st         <= ST_IDLE;
                        done_o     <= 1'b1;
                        done_err_o <= 1'b1;
                        abort_pend <= 1'b0;
                    end else if (!mem_busy_i) begin
                        st <= ST_MEM_RSP;
                    end
                end
                ST_MEM_RSP: begin
                    if (mem_ack_i) begin
                        cur_addr <= cur_addr + 32'(chunk_len);
                        mem_left <= mem_left - chunk_len;
                        if (mem_left == chunk_len)
                            st <= m2s ? ST_SEC : ST_REGION_END;
                        else
                            st <= ST_MEM;
                    end
                end
                ST_SEC: begin
                    if (abort_pend) begin
                        st         <= ST_IDLE;
                        done_o     <= 1'b1;
                        done_err_o <= 1'b1;
                        abort_pend <= 1'b0;
                    end else begin
                        st <= ST_SEC_RSP;
                    end
                end
                ST_SEC_RSP: begin
                    if (stor_ack_i) begin
                        lba      <= lba + 1'b1;
                        rem_cmd  <= rem_cmd - 32'(SECTOR_BYTES);
                        sec_left <= sec_left - 1'b1;
                        if (sec_left == LEN_W'(1))
                            st <= m2s ? ST_REGION_END : ST_MEM;
                        else
                            st <= ST_SEC;
                    end
                end
                ST_REGION_END: begin
                    if (abort_pend || last_q) begin
                        st         <= ST_IDLE;
                        done_o     <= 1'b1;
                        done_err_o <= abort_pend || (rem_cmd != '0);
                        abort_pend <= 1'b0;
                    end else begin
                        st <= ST_FETCH;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R3: a data request stays inside one page
    a_r3_page_bound: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !(mem_len_o == 17'd8)) |->
            ((17'(mem_addr_o[PG_W-1:0]) + mem_len_o) <= 17'(PAGE_BYTES)));

    // R4: never request into a busy port
    a_r4_no_req_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> !mem_busy_i);

    // R4: the backoff window is quiet
    a_r4_backoff_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BACKOFF) |-> !mem_req_o);

    // R7: completion leaves the engine idle
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> phase_o == PH_IDLE);

    // R5: a request lasts one cycle, one outstanding at a time
    a_r5_req_single: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o);

    // R10: an abort seen during transfer blocks sector requests from the next cycle
    a_r10_abort_no_sec: assert property (@(posedge clk) disable iff (rst)
        (abort_i && phase_o == PH_XFER) |=> !stor_req_o);

endmodule

// File: tb/tb_sg_dma_engine.sv
`timescale 1ns/100ps
module tb_sg_dma_engine;
    localparam int PAGE = 4096;
    localparam int BO   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        arm_i = 0, go_i = 0, to_storage_i = 0, abort_i = 0;
    logic [31:0] table_base_i = 0, lba_i = 0, cmd_bytes_i = 0;
    logic        mem_req_o, mem_we_o, mem_busy_i = 0, mem_ack_i = 0;
    logic [31:0] mem_addr_o;
    logic [16:0] mem_len_o;
    logic [63:0] mem_rdata_i = 0;
    logic        stor_req_o, stor_we_o, stor_ack_i = 0;
    logic [31:0] stor_lba_o;
    logic [1:0]  phase_o;
    logic        done_o, done_err_o, misuse_o;
    logic [31:0] rd_bytes_o, rd_txn_o, rd_full_o, wr_bytes_o, wr_txn_o, wr_full_o;

    sg_dma_engine #(.PAGE_BYTES(PAGE), .BACKOFF_CYC(BO), .STAT_W(32)) dut (
        .clk(clk), .rst(rst), .arm_i(arm_i), .go_i(go_i), .table_base_i(table_base_i),
        .to_storage_i(to_storage_i), .lba_i(lba_i), .cmd_bytes_i(cmd_bytes_i),
        .abort_i(abort_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o), .mem_busy_i(mem_busy_i),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .stor_req_o(stor_req_o),
        .stor_we_o(stor_we_o), .stor_lba_o(stor_lba_o), .stor_ack_i(stor_ack_i),
        .phase_o(phase_o), .done_o(done_o), .done_err_o(done_err_o), .misuse_o(misuse_o),
        .rd_bytes_o(rd_bytes_o), .rd_txn_o(rd_txn_o), .rd_full_o(rd_full_o),
        .wr_bytes_o(wr_bytes_o), .wr_txn_o(wr_txn_o), .wr_full_o(wr_full_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    bit finished = 0;

    // event log: kind 0 fetch, 1 mem read, 2 mem write, 3 sector read, 4 sector write
    int          obs_k [512];
    logic [31:0] obs_a [512];
    int          obs_l [512];
    int          obs_c [512];
    int          nobs = 0;
    int          exp_k [512];
    logic [31:0] exp_a [512];
    int          exp_l [512];
    int          nexp = 0;

    logic [31:0] d_base [8];
    logic [15:0] d_cnt  [8];
    int          nd = 1;
    logic [31:0] tb_al = 0;

    int          mpend = 0, spend = 0, force_cnt = 0;
    logic [63:0] mdata = 0;
    bit          rand_busy = 0, done_seen = 0, done_err_seen = 0, misuse_seen = 0;
    longint      e_bytes [2] = '{0, 0};
    longint      e_txn   [2] = '{0, 0};
    longint      e_full  [2] = '{0, 0};
    int          go_cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push_obs(input int k, input logic [31:0] a, input int l);
        if (nobs < 512) begin
            obs_k[nobs] = k; obs_a[nobs] = a; obs_l[nobs] = l; obs_c[nobs] = cyc;
            nobs++;
        end
    endtask

    // responder: inputs change at the falling edge, outputs sampled 1 ns later
    initial begin
        forever begin
            @(negedge clk);
            mem_ack_i  = 0;
            stor_ack_i = 0;
            if (mpend > 0) begin
                mpend--;
                if (mpend == 0) begin mem_ack_i = 1; mem_rdata_i = mdata; end
            end
            if (spend > 0) begin
                spend--;
                if (spend == 0) stor_ack_i = 1;
            end
            if (force_cnt > 0) begin
                mem_busy_i = 1; force_cnt--;
            end else begin
                mem_busy_i = rand_busy && ($urandom % 4 == 0);
            end
            #1;
            if (mem_req_o) begin
                mpend = 1 + int'($urandom % 3);
                if (mem_len_o == 17'd8) begin
                    int idx;
                    idx = int'((mem_addr_o - tb_al) >> 3);
                    push_obs(0, mem_addr_o, 8);
                    if (idx >= 0 && idx < 8)
                        mdata = {(idx == nd - 1), 15'd0, d_cnt[idx], d_base[idx]};
                    else
                        mdata = 64'd0;
                end else begin
                    push_obs(mem_we_o ? 2 : 1, mem_addr_o, int'(mem_len_o));
                    mdata = 64'd0;
                end
            end
            if (stor_req_o) begin
                push_obs(stor_we_o ? 4 : 3, stor_lba_o, 0);
                spend = 1 + int'($urandom % 2);
            end
            if (done_o) begin done_seen = 1; done_err_seen = done_err_o; end
            if (misuse_o) misuse_seen = 1;
        end
    end

    task automatic push_exp(input int k, input logic [31:0] a, input int l);
        if (nexp < 512) begin
            exp_k[nexp] = k; exp_a[nexp] = a; exp_l[nexp] = l; nexp++;
        end
    endtask

    task automatic exp_chunks(input int k, input logic [31:0] base, input int cnt);
        logic [31:0] a;
        int left, l, to_pg;
        a = base; left = cnt;
        while (left > 0) begin
            to_pg = PAGE - int'(a % PAGE);
            l = (left < to_pg) ? left : to_pg;
            push_exp(k, a, l);
            e_bytes[k-1] += l; e_txn[k-1] += 1;
            if (l == PAGE) e_full[k-1] += 1;
            a += 32'(l); left -= l;
        end
    endtask

    task automatic build_exp(input bit to_stor, input logic [31:0] lba0, output int total);
        logic [31:0] lba;
        int cnt;
        nexp = 0; lba = lba0; total = 0;
        for (int i = 0; i < nd; i++) begin
            push_exp(0, tb_al + 32'(8 * i), 8);
            cnt = (d_cnt[i] == 16'd0) ? 65536 : int'(d_cnt[i]);
            total += cnt;
            if (to_stor) begin
                exp_chunks(1, d_base[i], cnt);
                for (int s = 0; s < cnt / 512; s++) begin push_exp(4, lba, 0); lba++; end
            end else begin
                for (int s = 0; s < cnt / 512; s++) begin push_exp(3, lba, 0); lba++; end
                exp_chunks(2, d_base[i], cnt);
            end
        end
    endtask

    task automatic wait_done(input string req);
        int t;
        t = 0;
        while (!done_seen && t < 30000) begin @(negedge clk); t++; end
        chk(done_seen, req, "done pulse seen", done_seen, 1);
        @(negedge clk);
    endtask

    task automatic start_cmd(input logic [31:0] tprog, input bit to_stor,
                             input logic [31:0] lba0, input logic [31:0] cmdb,
                             input bit busy_en, input int fcnt);
        @(posedge clk);
        rand_busy = busy_en; force_cnt = fcnt; nobs = 0; done_seen = 0; misuse_seen = 0;
        @(negedge clk);
        arm_i = 1;
        @(negedge clk);
        arm_i = 0;
        chk(phase_o == 2'd1, "R9", "phase armed", phase_o, 1);
        go_i = 1; table_base_i = tprog; to_storage_i = to_stor; lba_i = lba0;
        cmd_bytes_i = cmdb; go_cyc = cyc;
        @(negedge clk);
        go_i = 0;
    endtask

    task automatic check_stats(input string tag);
        chk(rd_bytes_o == e_bytes[0] && rd_txn_o == e_txn[0] && rd_full_o == e_full[0],
            "R8", {tag, " read counters (bytes)"}, rd_bytes_o, e_bytes[0]);
        chk(wr_bytes_o == e_bytes[1] && wr_txn_o == e_txn[1] && wr_full_o == e_full[1],
            "R8", {tag, " write counters (bytes)"}, wr_bytes_o, e_bytes[1]);
    endtask

    task automatic run_xfer(input bit to_stor, input logic [31:0] tprog,
                            input logic [31:0] lba0, input int extra_sec,
                            input bit busy_en, input int fcnt, input string tag);
        int total, bad;
        tb_al = {tprog[31:2], 2'b00};
        build_exp(to_stor, lba0, total);
        start_cmd(tprog, to_stor, lba0, 32'(total + extra_sec * 512), busy_en, fcnt);
        wait_done("R7");
        bad = -1;
        for (int i = 0; i < nexp; i++)
            if (bad < 0 && (i >= nobs || obs_k[i] != exp_k[i] || obs_a[i] != exp_a[i]
                            || obs_l[i] != exp_l[i])) bad = i;
        chk(nobs == nexp && bad < 0, to_stor ? "R5 R3 R2" : "R6 R3 R2",
            {tag, " event list (first bad index)"}, bad, -1);
        chk(nobs > 0 && obs_a[0] == tb_al, "R1", {tag, " first fetch address"},
            obs_a[0], tb_al);
        chk(done_err_seen == (extra_sec != 0), "R7", {tag, " error flag"},
            done_err_seen, extra_sec != 0);
        chk(phase_o == 2'd0, "R7", {tag, " phase idle after done"}, phase_o, 0);
        check_stats(tag);
    endtask

    initial begin
        int ab_cyc, late;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk(phase_o == 0 && !mem_req_o && !stor_req_o && !done_o && !misuse_o,
            "R11", "idle outputs after reset", phase_o, 0);
        chk(rd_bytes_o == 0 && wr_bytes_o == 0 && rd_txn_o == 0 && wr_txn_o == 0
            && rd_full_o == 0 && wr_full_o == 0, "R11", "counters zero", rd_bytes_o, 0);

        // R1 R3 R5: one region crossing a page, low table bits set
        nd = 1; d_base[0] = 32'h1000_0E00; d_cnt[0] = 16'd4096;
        run_xfer(1, 32'h2000_0003, 32'd100, 0, 0, 0, "page-cross");
        chk(obs_c[0] - go_cyc == 1, "R4", "fetch delay without busy", obs_c[0] - go_cyc, 1);

        // R2 R6 R8: count 0 means 64 KiB, page aligned, toward memory
        nd = 1; d_base[0] = 32'h4000_0000; d_cnt[0] = 16'd0;
        run_xfer(0, 32'h2100_0000, 32'd7, 0, 0, 0, "64k");

        // R4 backoff: busy during the fetch cycle only
        nd = 1; d_base[0] = 32'h5000_0200; d_cnt[0] = 16'd512;
        run_xfer(1, 32'h2200_0010, 32'd5, 0, 0, 3, "backoff");
        chk(obs_c[0] - go_cyc == BO + 2, "R4", "fetch delay after busy",
            obs_c[0] - go_cyc, BO + 2);

        // random chains, both directions, random busy
        for (int r = 0; r < 8; r++) begin
            nd = 1 + int'($urandom % 4);
            for (int i = 0; i < nd; i++) begin
                d_base[i] = 32'h1000_0000 + 32'(i) * 32'h0002_0000 + ($urandom % 16) * 512;
                d_cnt[i]  = 16'((1 + $urandom % 12) * 512);
            end
            run_xfer(1'($urandom % 2), 32'h2000_0000 + ($urandom % 32) * 8 + ($urandom % 4),
                     $urandom % 1000, 0, 1, 0, "random");
        end

        // R7 byte total mismatch
        nd = 2; d_base[0] = 32'h6000_0000; d_cnt[0] = 16'd1024;
        d_base[1] = 32'h6000_1F00; d_cnt[1] = 16'd512;
        run_xfer(0, 32'h2300_0000, 32'd40, 1, 0, 0, "mismatch");

        // R10 abort mid transfer (counters not tracked afterwards)
        nd = 1; d_base[0] = 32'h7000_0000; d_cnt[0] = 16'd8192;
        tb_al = 32'h2400_0000;
        build_exp(1, 0, late);
        start_cmd(32'h2400_0000, 1, 32'd0, 32'd8192, 0, 0);
        while (nobs < 2) @(negedge clk);
        abort_i = 1; ab_cyc = cyc;
        @(negedge clk);
        abort_i = 0;
        wait_done("R10");
        chk(done_err_seen == 1, "R10", "abort error flag", done_err_seen, 1);
        late = 0;
        for (int i = 0; i < nobs; i++) if (obs_c[i] > ab_cyc) late++;
        chk(late == 0, "R10", "requests after abort", late, 0);
        chk(nobs < nexp, "R10", "transfer cut short", nobs, nexp);

        // R10 abort while armed
        @(posedge clk); nobs = 0; done_seen = 0;
        @(negedge clk); arm_i = 1;
        @(negedge clk); arm_i = 0; abort_i = 1;
        @(negedge clk); abort_i = 0;
        @(negedge clk);
        chk(done_seen && done_err_seen, "R10", "armed abort error done", done_err_seen, 1);
        chk(nobs == 0 && phase_o == 0, "R10", "armed abort no requests", nobs, 0);

        // R9 misuse in idle
        @(posedge clk); misuse_seen = 0; nobs = 0;
        @(negedge clk); go_i = 1; table_base_i = 32'h2500_0000;
        @(negedge clk); go_i = 0;
        @(negedge clk);
        chk(misuse_seen && phase_o == 0, "R9", "go in idle flagged", misuse_seen, 1);
        @(posedge clk); misuse_seen = 0;
        @(negedge clk); abort_i = 1;
        @(negedge clk); abort_i = 0;
        repeat (3) @(negedge clk);
        chk(misuse_seen && phase_o == 0 && nobs == 0, "R9", "abort in idle flagged",
            misuse_seen, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule